// File: doc/BRIEF.md
# DAC Input Source Selector with Loopback

This block decides which stereo sample stream reaches a DAC datapath. Two external serial audio lines share one deserializer, and a single select bit chooses between them, so the board needs no multiplexer of its own. The deserializer reads left and right words in one of four interface formats. It presents each finished left/right pair as two parallel 24-bit words, together with a one-cycle valid pulse. At the same time the block serializes parallel ADC samples onto a serial output line, in a one-bit ADC format.

In loopback, the line being deserialized is the block's own serial output. ADC words therefore reach the DAC side in place of either external line, and the DAC side reads them with the ADC format. The DAC format field is ignored while loopback is active. The field value present when loopback is cleared takes effect at the next frame start. All DAC-side settings are latched only when a left half-frame begins, so a word that is half received is never reinterpreted.

A clocking-change pulse forces the next MUTE_PAIRS emitted pairs to zero, whatever data arrives. All inputs are sampled levels in the `clk` domain. The bit clock and frame clock are edge-detected internally, and a frame clock falling edge starts the left half.

Top module: `dac_src_sel`

## Requirements
- R1: With loopback off, `srcSel`=0 takes DAC data from `serIn0` and `srcSel`=1 takes it from `serIn1`. The unselected line has no effect on the output.
- R2: With loopback on, each emitted pair equals the ADC pair that was serialized on `serOut` during the same frame.
- R3: While loopback is on, `dacFmt` has no effect on the DAC words, and the looped data is read in the ADC format.
- R4: A `dacFmt` value written during loopback is used from the first frame that starts with loopback off.
- R5: `serOut` always carries the ADC words in the `adcFmt` format, whatever the loopback setting. The encodings are 0 = left-justified (MSB in slot bit 0) and 1 = I2S (MSB in slot bit 1), with 24 bits MSB first. The line changes only after bit clock falling edges.
- R6: After a `clkChange` pulse, the next MUTE_PAIRS emitted pairs are all zero.
- R7: `dacFmt` encodings:
  - 00 reads 24 bits from slot bit 0.
  - 01 reads 24 bits from slot bit 1.
  - 10 reads the last 16 bits of the slot and outputs them as {word, 8'h00}.
  - 11 reads the last 24 bits of the slot.
  - Slot bits outside the window are ignored.
- R8: `srcSel`, `loopEn`, `dacFmt` and `adcFmt` are sampled only at a frame clock falling edge. Changes in mid-frame do not affect that frame.
- R9: Each complete left-then-right frame gives exactly one `dacValid` pulse, one cycle wide, at the next frame clock falling edge, with both words held until the next pulse.
- R10: After reset, `dacValid`, `dacLeft`, `dacRight` and `serOut` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| bitClk | input | 1 | Serial bit clock level |
| frameClk | input | 1 | Frame clock level, low = left half |
| serIn0 | input | 1 | External serial data line 0 |
| serIn1 | input | 1 | External serial data line 1 |
| srcSel | input | 1 | External line select |
| loopEn | input | 1 | Loopback enable |
| dacFmt | input | 2 | DAC interface format |
| adcFmt | input | 1 | ADC interface format |
| clkChange | input | 1 | Clocking change pulse |
| adcLeft | input | 24 | ADC left sample |
| adcRight | input | 24 | ADC right sample |
| adcValid | input | 1 | ADC pair strobe |
| dacLeft | output | 24 | DAC left word |
| dacRight | output | 24 | DAC right word |
| dacValid | output | 1 | Pair valid pulse |
| serOut | output | 1 | Serial ADC output |

## Verification
The assertions check several behaviours on every cycle:
- latched settings stay stable between frame starts;
- the looped path only ever uses a 24-bit justified format;
- the valid pulse is one cycle wide;
- every muted pulse carries zero words;
- 16-bit words have a zero low byte;
- the serial output moves only after bit clock falls.

Whether the right line was chosen, and whether each format's window and bit order are correct, can only be shown by the bench's sweeps. The same holds for the pending-format hand-over out of loopback and for the exact count of muted pairs. The bench drives every format with both lines, using deliberately mismatched out-of-window bits and mid-frame setting changes, and compares each pair against words rebuilt arithmetically.

// File: rtl/dac_src_pkg.sv
package dac_src_pkg;
  localparam int WORD_W  = 24;
  localparam int SHORT_W = 16;

  typedef enum logic [1:0] {
    FMT_LJ24  = 2'b00,
    FMT_I2S24 = 2'b01,
    FMT_RJ16  = 2'b10,
    FMT_RJ24  = 2'b11
  } dac_fmt_e;

  typedef struct packed {
    logic     bitRise;
    logic     bitFall;
    logic     frameEdge;
    logic     leftStart;
    logic     emitPair;
    logic     mute;
    logic     useLoop;
    logic     lineSel;
    dac_fmt_e deserFmt;
    logic     serI2s;
  } strobe_t;
endpackage

// File: rtl/dac_src_ctrl.sv
module dac_src_ctrl
  import dac_src_pkg::*;
#(
  parameter int MUTE_PAIRS = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       bitClk,
  input  logic       frameClk,
  input  logic       srcSel,
  input  logic       loopEn,
  input  logic [1:0] dacFmt,
  input  logic       adcFmt,
  input  logic       clkChange,
  output strobe_t    strb
);
  localparam int MUTE_W = $clog2(MUTE_PAIRS + 1);

  typedef enum logic [1:0] {PH_IDLE, PH_LEFT, PH_RIGHT} phase_e;

  logic bPrev, fPrev;
  phase_e phase;
  logic loopL, srcL, adcFmtL;
  dac_fmt_e dacFmtL;
  logic [MUTE_W-1:0] muteCnt;

  logic bitRise, bitFall, frameEdge, leftStart, rightStart, emitPair;
  dac_fmt_e effFmt;

  always_comb begin
    bitRise    = bitClk & ~bPrev;
    bitFall    = ~bitClk & bPrev;
    frameEdge  = frameClk ^ fPrev;
    leftStart  = frameEdge & ~frameClk;
    rightStart = frameEdge & frameClk;
    emitPair   = leftStart && (phase == PH_RIGHT);
    effFmt     = loopL ? (adcFmtL ? FMT_I2S24 : FMT_LJ24) : dacFmtL;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      bPrev   <= 1'b1;
      fPrev   <= 1'b1;
      phase   <= PH_IDLE;
      loopL   <= 1'b0;
      srcL    <= 1'b0;
      adcFmtL <= 1'b0;
      dacFmtL <= FMT_LJ24;
      muteCnt <= '0;
    end else begin
      bPrev <= bitClk;
      fPrev <= frameClk;
      if (leftStart) begin
        phase   <= PH_LEFT;
        loopL   <= loopEn;
        srcL    <= srcSel;
        adcFmtL <= adcFmt;
        dacFmtL <= dac_fmt_e'(dacFmt);
      end else if (rightStart && phase == PH_LEFT) begin
        phase <= PH_RIGHT;
      end
      if (clkChange)
        muteCnt <= MUTE_W'(MUTE_PAIRS);
      else if (emitPair && muteCnt != '0)
        muteCnt <= muteCnt - 1'b1;
    end
  end

  always_comb begin
    strb.bitRise   = bitRise;
    strb.bitFall   = bitFall;
    strb.frameEdge = frameEdge;
    strb.leftStart = leftStart;
    strb.emitPair  = emitPair;
    strb.mute      = clkChange || (muteCnt != '0);
    strb.useLoop   = loopL;
    strb.lineSel   = srcL;
    strb.deserFmt  = effFmt;
    strb.serI2s    = leftStart ? adcFmt : adcFmtL;
  end

  // R8: settings only move at a left-half start
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    !leftStart |=> $stable({loopL, srcL, adcFmtL, dacFmtL}));

  // R3: looped data is always read with a 24-bit justified format
  p_loop_fmt_r3: assert property (@(posedge clk) disable iff (!rstN)
    strb.useLoop |-> (strb.deserFmt == FMT_LJ24 || strb.deserFmt == FMT_I2S24));

  // R6: a clocking change mutes from the next cycle on
  p_mute_armed_r6: assert property (@(posedge clk) disable iff (!rstN)
    clkChange |=> strb.mute);
endmodule

// File: rtl/dac_src_dpath.sv
module dac_src_dpath
  import dac_src_pkg::*;
#(
  parameter int SLOT_BITS = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              serIn0,
  input  logic              serIn1,
  input  logic [WORD_W-1:0] adcLeft,
  input  logic [WORD_W-1:0] adcRight,
  input  logic              adcValid,
  output logic [WORD_W-1:0] dacLeft,
  output logic [WORD_W-1:0] dacRight,
  output logic              dacValid,
  output logic              serOut
);
  localparam int CNT_W = $clog2(SLOT_BITS + 1);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SLOT_BITS);

  function automatic logic inWindow(dac_fmt_e f, logic [CNT_W-1:0] idx);
    int i;
    i = int'(idx);
    case (f)
      FMT_LJ24:  return i < WORD_W;
      FMT_I2S24: return (i >= 1) && (i <= WORD_W);
      FMT_RJ16:  return (i >= SLOT_BITS - SHORT_W) && (i < SLOT_BITS);
      default:   return (i >= SLOT_BITS - WORD_W) && (i < SLOT_BITS);
    endcase
  endfunction

  function automatic logic serBit(logic [WORD_W-1:0] w, logic [CNT_W-1:0] idx, logic i2s);
    int pos;
    pos = i2s ? int'(idx) - 1 : int'(idx);
    if (pos >= 0 && pos < WORD_W)
      return w[IDX_W'(WORD_W - 1 - pos)];
    return 1'b0;
  endfunction

  function automatic logic [WORD_W-1:0] alignWord(logic [WORD_W-1:0] sr, dac_fmt_e f);
    if (f == FMT_RJ16)
      return {sr[SHORT_W-1:0], {(WORD_W - SHORT_W){1'b0}}};
    return sr;
  endfunction

  // serializer
  logic [WORD_W-1:0] holdL, holdR, curR, serWord;
  logic [CNT_W-1:0]  outCnt;
  logic              serOutR;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdL   <= '0;
      holdR   <= '0;
      curR    <= '0;
      serWord <= '0;
      outCnt  <= '0;
      serOutR <= 1'b0;
    end else begin
      if (adcValid) begin
        holdL <= adcLeft;
        holdR <= adcRight;
      end
      if (strb.frameEdge) begin
        outCnt <= CNT_W'(1);
        if (strb.leftStart) begin
          serWord <= holdL;
          curR    <= holdR;
          serOutR <= serBit(holdL, '0, strb.serI2s);
        end else begin
          serWord <= curR;
          serOutR <= serBit(curR, '0, strb.serI2s);
        end
      end else if (strb.bitFall) begin
        serOutR <= serBit(serWord, outCnt, strb.serI2s);
        if (outCnt != CNT_MAX) outCnt <= outCnt + 1'b1;
      end
    end
  end

  assign serOut = serOutR;

  // deserializer
  logic              lineBit;
  logic [WORD_W-1:0] shiftReg, leftW, doneWord;
  logic [CNT_W-1:0]  inCnt;

  always_comb begin
    lineBit  = strb.useLoop ? serOutR : (strb.lineSel ? serIn1 : serIn0);
    doneWord = alignWord(shiftReg, strb.deserFmt);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      leftW    <= '0;
      inCnt    <= '0;
      dacLeft  <= '0;
      dacRight <= '0;
      dacValid <= 1'b0;
    end else begin
      dacValid <= strb.emitPair;
      if (strb.frameEdge) begin
        shiftReg <= '0;
        inCnt    <= '0;
        if (!strb.leftStart) leftW <= doneWord;
        if (strb.emitPair) begin
          dacLeft  <= strb.mute ? '0 : leftW;
          dacRight <= strb.mute ? '0 : doneWord;
        end
      end else if (strb.bitRise) begin
        if (inWindow(strb.deserFmt, inCnt)) shiftReg <= {shiftReg[WORD_W-2:0], lineBit};
        if (inCnt != CNT_MAX) inCnt <= inCnt + 1'b1;
      end
    end
  end

  // R9: valid is a single-cycle pulse following a pair completion
  p_valid_single_r9: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |=> !dacValid);
  p_valid_origin_r9: assert property (@(posedge clk) disable iff (!rstN)
    dacValid |-> $past(strb.emitPair));

  // R6: muted pairs carry zero words
  p_zero_when_muted_r6: assert property (@(posedge clk) disable iff (!rstN)
    (dacValid && $past(strb.mute)) |-> (dacLeft == '0 && dacRight == '0));

  // R7: 16-bit words come out with a zero low byte
  p_rj16_fill_r7: assert property (@(posedge clk) disable iff (!rstN)
    (dacValid && $past(strb.deserFmt == FMT_RJ16))
      |-> (dacLeft[WORD_W-SHORT_W-1:0] == '0 && dacRight[WORD_W-SHORT_W-1:0] == '0));

  // R5: serial output only moves after a bit clock falling edge
  p_ser_on_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strb.bitFall) |-> $stable(serOut));
endmodule

// File: rtl/dac_src_sel.sv
module dac_src_sel
  import dac_src_pkg::*;
#(
  parameter int SLOT_BITS  = 32,
  parameter int MUTE_PAIRS = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              bitClk,
  input  logic              frameClk,
  input  logic              serIn0,
  input  logic              serIn1,
  input  logic              srcSel,
  input  logic              loopEn,
  input  logic [1:0]        dacFmt,
  input  logic              adcFmt,
  input  logic              clkChange,
  input  logic [WORD_W-1:0] adcLeft,
  input  logic [WORD_W-1:0] adcRight,
  input  logic              adcValid,
  output logic [WORD_W-1:0] dacLeft,
  output logic [WORD_W-1:0] dacRight,
  output logic              dacValid,
  output logic              serOut
);
  strobe_t strb;

  dac_src_ctrl #(.MUTE_PAIRS(MUTE_PAIRS)) uCtrl (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .srcSel(srcSel), .loopEn(loopEn), .dacFmt(dacFmt), .adcFmt(adcFmt),
    .clkChange(clkChange), .strb(strb)
  );

  dac_src_dpath #(.SLOT_BITS(SLOT_BITS)) uDpath (
    .clk(clk), .rstN(rstN), .strb(strb), .serIn0(serIn0), .serIn1(serIn1),
    .adcLeft(adcLeft), .adcRight(adcRight), .adcValid(adcValid),
    .dacLeft(dacLeft), .dacRight(dacRight), .dacValid(dacValid), .serOut(serOut)
  );
endmodule

// File: tb/tb_dac_src_sel.sv
module tb_dac_src_sel;
  localparam int SLOT = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic bitClk = 1'b1, frameClk = 1'b1;
  logic serIn0 = 1'b0, serIn1 = 1'b0;
  logic srcSel = 1'b0, loopEn = 1'b0, adcFmt = 1'b0, clkChange = 1'b0, adcValid = 1'b0;
  logic [1:0] dacFmt = 2'b00;
  logic [23:0] adcLeft = '0, adcRight = '0;
  logic [23:0] dacLeft, dacRight;
  logic dacValid, serOut;

  int checks = 0;
  int fails = 0;
  logic [23:0] expL[$];
  logic [23:0] expR[$];
  string expTag[$];
  logic [23:0] curAdcL = '0, curAdcR = '0, pendAdcL = '0, pendAdcR = '0;
  int muteLeft = 0;

  always #4 clk = ~clk;

  dac_src_sel #(.SLOT_BITS(SLOT), .MUTE_PAIRS(2)) dut (
    .clk(clk), .rstN(rstN), .bitClk(bitClk), .frameClk(frameClk),
    .serIn0(serIn0), .serIn1(serIn1), .srcSel(srcSel), .loopEn(loopEn),
    .dacFmt(dacFmt), .adcFmt(adcFmt), .clkChange(clkChange),
    .adcLeft(adcLeft), .adcRight(adcRight), .adcValid(adcValid),
    .dacLeft(dacLeft), .dacRight(dacRight), .dacValid(dacValid), .serOut(serOut)
  );

  function automatic logic [23:0] mkWord(int k);
    return {8'(k * 37 + 11), 8'(k * 91 + 5), 8'(k * 13 + 200)};
  endfunction

  // out-of-window slot bits are driven to 1 so that a window error shows
  function automatic logic lineBit(logic [23:0] w, int idx, logic [1:0] f);
    case (f)
      2'b00:   return (idx < 24) ? w[23 - idx] : 1'b1;
      2'b01:   return (idx >= 1 && idx <= 24) ? w[24 - idx] : 1'b1;
      2'b10:   return (idx >= SLOT - 16) ? w[SLOT - 1 - idx + 8] : 1'b1;
      default: return (idx >= SLOT - 24) ? w[SLOT - 1 - idx] : 1'b1;
    endcase
  endfunction

  function automatic logic [23:0] fmtExp(logic [23:0] w, logic [1:0] f);
    return (f == 2'b10) ? {w[23:8], 8'h00} : w;
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN && dacValid) begin
      if (expL.size() == 0) begin
        checks++;
        fails++;
        $display("FAIL R9: actual unexpected pair %h/%h expected no pulse", dacLeft, dacRight);
      end else begin
        automatic string t = expTag.pop_front();
        check(t, dacLeft, expL.pop_front());
        check(t, dacRight, expR.pop_front());
      end
    end
  end

  task automatic sendFrame(string tag, logic [1:0] f, logic src, logic loop, logic af,
                           int k, logic chg);
    logic [23:0] w0L, w0R, w1L, w1R, recL, recR, eL, eR;
    w0L = mkWord(k);     w0R = mkWord(k + 100);
    w1L = mkWord(k + 7); w1R = mkWord(k + 300);
    curAdcL = pendAdcL; curAdcR = pendAdcR;
    recL = '0; recR = '0;
    dacFmt = f; srcSel = src; loopEn = loop; adcFmt = af;
    for (int h = 0; h < 2; h++) begin
      for (int idx = 0; idx < SLOT; idx++) begin
        bitClk = 1'b0;
        frameClk = (h == 1);
        serIn0 = lineBit(h ? w0R : w0L, idx, f);
        serIn1 = lineBit(h ? w1R : w1L, idx, f);
        if (h == 0 && idx == 10) begin
          pendAdcL = mkWord(k + 500); pendAdcR = mkWord(k + 900);
          adcLeft = pendAdcL; adcRight = pendAdcR; adcValid = 1'b1;
        end
        if (h == 0 && idx == 5 && chg) clkChange = 1'b1;
        if (h == 0 && idx == 20) begin
          // R8: mid-frame changes must not touch this frame
          dacFmt = ~f; srcSel = ~src; loopEn = ~loop; adcFmt = ~af;
        end
        @(negedge clk);
        adcValid = 1'b0; clkChange = 1'b0;
        repeat (3) @(negedge clk);
        bitClk = 1'b1;
        if (af ? (idx >= 1 && idx <= 24) : (idx < 24)) begin
          if (h == 0) recL[af ? 24 - idx : 23 - idx] = serOut;
          else        recR[af ? 24 - idx : 23 - idx] = serOut;
        end
        repeat (4) @(negedge clk);
      end
    end
    check("R5 serOut left", recL, curAdcL);
    check("R5 serOut right", recR, curAdcR);
    if (chg) muteLeft = 2;
    if (loop) begin
      eL = curAdcL; eR = curAdcR;
    end else begin
      eL = fmtExp(src ? w1L : w0L, f);
      eR = fmtExp(src ? w1R : w0R, f);
    end
    if (muteLeft > 0) begin
      eL = '0; eR = '0; muteLeft--;
    end
    expL.push_back(eL); expR.push_back(eR); expTag.push_back(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int k;
    k = 1;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 dacLeft", dacLeft, '0);
    check("R10 dacRight", dacRight, '0);
    check("R10 valid/serOut", {22'd0, dacValid, serOut}, '0);

    // R1 R7: every format on both external lines
    for (int f = 0; f < 4; f++) begin
      for (int s = 0; s < 2; s++) begin
        sendFrame((s == 0) ? "R1 R7 line0" : "R1 R7 line1", 2'(f), 1'(s), 1'b0, 1'(f & 1), k, 1'b0);
        k++;
      end
    end
    // R2 R3: loopback with each DAC format value and both ADC formats
    for (int a = 0; a < 2; a++) begin
      for (int f = 0; f < 4; f++) begin
        sendFrame("R2 R3 loopback", 2'(f), 1'(f >> 1), 1'b1, 1'(a), k, 1'b0);
        k++;
      end
    end
    // R4: format written during loopback takes effect once loopback clears
    sendFrame("R3 loopback hold", 2'b11, 1'b0, 1'b1, 1'b0, k, 1'b0); k++;
    sendFrame("R4 pending fmt", 2'b10, 1'b1, 1'b0, 1'b1, k, 1'b0); k++;
    sendFrame("R4 pending fmt", 2'b01, 1'b0, 1'b0, 1'b0, k, 1'b0); k++;
    // R6: clocking change mutes two pairs, then data returns
    sendFrame("R6 mute", 2'b00, 1'b0, 1'b0, 1'b0, k, 1'b1); k++;
    sendFrame("R6 mute", 2'b11, 1'b1, 1'b0, 1'b1, k, 1'b0); k++;
    sendFrame("R6 after mute", 2'b10, 1'b0, 1'b0, 1'b0, k, 1'b0); k++;
    sendFrame("R6 mute loop", 2'b00, 1'b0, 1'b1, 1'b1, k, 1'b1); k++;
    sendFrame("R6 mute loop", 2'b00, 1'b0, 1'b1, 1'b0, k, 1'b0); k++;
    sendFrame("R2 after mute", 2'b01, 1'b0, 1'b1, 1'b0, k, 1'b0); k++;
    // flush frame: emits the last pair, its own pair is never completed
    sendFrame("flush", 2'b00, 1'b0, 1'b0, 1'b0, k, 1'b0);
    void'(expL.pop_back()); void'(expR.pop_back()); void'(expTag.pop_back());
    repeat (20) @(negedge clk);
    checks++;
    if (expL.size() != 0) begin
      fails++;
      $display("FAIL R9: actual %0d pairs missing expected 0", expL.size());
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule